// File: doc/BRIEF.md
# Posted-Write Buffer with Read Bypass and Forwarding

This block sits between a single requester and a memory port. Writes from the requester are taken into a small address-tagged store and acknowledged at once. They are written to memory later as one back-to-back burst. Reads do not wait behind those queued writes. A read whose address is held in the store is answered from the store in one cycle, with the newest data. A read that finds no match goes straight to the memory read channel, even while writes are still queued.

A write to an address already held in the store replaces that entry's data and keeps its place in the queue, so each address appears at most once. A burst starts when occupancy reaches a high-water mark, when the store is full, or when the flush input is raised while entries are held. The burst writes every held entry in arrival order. The block assumes that memory applies a write accepted on the write channel before it serves any read request accepted after it.

Top module: `pwb_top`

## Requirements
- R1: After reset no memory traffic occurs, no response is valid, and a write request sees `req_ready` high.
- R2: Writes accepted while occupancy is below the high-water mark (default 6), with `flush` low, produce no activity on the memory write channel.
- R3: Once occupancy reaches the high-water mark, the block writes every held entry in arrival order as one burst. `mwr_len` equals the beat count on every beat, and `mwr_last` is high on the final beat only.
- R4: A `flush` pulse with entries held starts a burst of those entries. A `flush` pulse with the store empty produces no write traffic.
- R5: A read that matches a held address is answered with `rsp_valid` and `rsp_hit` high in the cycle after acceptance, and issues no memory read.
- R6: A write to an address already held overwrites its data in place. A later read returns the newest data, and the burst carries that address once, at its original position.
- R7: A read with no match issues exactly one memory read, and its response carries the memory data with `rsp_hit` low.
- R8: A missing read is issued to memory while older writes are still held, without waiting for them to drain.
- R9: While a burst is starting or in progress, or the store is full, writes to new addresses see `req_ready` low. Reads are still accepted.
- R10: A write beat stalled by `mwr_ready` low keeps `mwr_valid`, `mwr_addr` and `mwr_data` unchanged until it is taken.
- R11: Only one read is outstanding. While a memory read is pending, reads see `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester command valid |
| req_ready | output | 1 | Command accepted this cycle when high with `req_valid` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW | Read response data |
| rsp_hit | output | 1 | Response was served from the store |
| flush | input | 1 | Request a burst of all held entries |
| mrd_valid | output | 1 | Memory read request valid |
| mrd_ready | input | 1 | Memory read request accepted |
| mrd_addr | output | AW | Memory read address |
| mrd_rvalid | input | 1 | Memory read data valid |
| mrd_rdata | input | DW | Memory read data |
| mwr_valid | output | 1 | Memory write beat valid |
| mwr_ready | input | 1 | Memory write beat accepted |
| mwr_addr | output | AW | Memory write address |
| mwr_data | output | DW | Memory write data |
| mwr_len | output | CW | Beat count of the current burst |
| mwr_last | output | 1 | Final beat of the burst |

## Verification
A lost or stale tag in the store shows up at the ports in two ways. A read that should hit goes to memory instead, and a burst has the wrong length or order. Both are visible within a few cycles of the read or the burst. A head or tail pointer that slips shows as a beat with the wrong address or data in the burst that follows. A wrong occupancy count starts a burst too early or too late relative to the sixth distinct write. A broken read state machine shows either as a response whose latency is not one cycle on a hit, or as `req_ready` that stays high while a miss is pending.

// File: rtl/pwb_pkg.sv
// Shared state encodings for the posted-write buffer.
package pwb_pkg;
    typedef enum logic {
        DR_IDLE,
        DR_BURST
    } drain_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ISSUE,
        RD_WAIT
    } rd_state_e;
endpackage

// File: rtl/pwb_store.sv
// Address-tagged entry store kept as a circular queue in arrival order.
// A push to an address already present overwrites that entry's data in place;
// otherwise it allocates at the tail. Pops retire the head.
// Assumes push and pop never occur in the same cycle (the top blocks writes
// while draining) and that the caller never pushes a new address when full.
module pwb_store #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] look_addr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [AW-1:0]    tag_q  [DEPTH];
    logic [DW-1:0]    word_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [PW-1:0]    head_q;
    logic [PW-1:0]    tail_q;
    logic [CW-1:0]    cnt_q;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    match_idx;
    logic             alloc;

    // Per-slot tag comparators.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = live_q[g] && (tag_q[g] == look_addr);
    end

    // Encode the matching slot; at most one slot can match.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) match_idx = PW'(i);
        end
    end

    assign hit       = |match;
    assign hit_data  = word_q[match_idx];
    assign head_addr = tag_q[head_q];
    assign head_data = word_q[head_q];
    assign count     = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));
    assign alloc     = push && !hit;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc) begin
                live_q[tail_q] <= 1'b1;
                tail_q <= (tail_q == PW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
            end
            if (pop) begin
                live_q[head_q] <= 1'b0;
                head_q <= (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(alloc) - CW'(pop);
        end
    end

    // Tag and data storage: allocate at tail or coalesce onto the match.
    always_ff @(posedge clk) begin
        if (alloc) begin
            tag_q[tail_q]  <= look_addr;
            word_q[tail_q] <= push_data;
        end else if (push) begin
            word_q[match_idx] <= push_data;
        end
    end

    p_match_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (cnt_q < CW'(DEPTH)));
    p_push_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/pwb_drain.sv
// Burst drain sequencer. Decides when to empty the store and emits one beat
// per held entry, head first, on the memory write channel.
// Assumes the store is not pushed while a burst is starting or running.
module pwb_drain #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int HIWAT = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          flush,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    output logic          start,
    output logic          draining,
    output logic          pop,
    output logic          mwr_valid,
    input  logic          mwr_ready,
    output logic [AW-1:0] mwr_addr,
    output logic [DW-1:0] mwr_data,
    output logic [CW-1:0] mwr_len,
    output logic          mwr_last
);
    import pwb_pkg::*;

    drain_state_e  state_q;
    logic [CW-1:0] left_q;
    logic [CW-1:0] len_q;

    // Trigger: high-water mark, full store, or flush, with something held.
    assign start = (state_q == DR_IDLE) && (count != '0) &&
                   ((count >= CW'(HIWAT)) || (count == CW'(DEPTH)) || flush);

    assign draining  = (state_q == DR_BURST);
    assign mwr_valid = draining;
    assign mwr_addr  = head_addr;
    assign mwr_data  = head_data;
    assign mwr_len   = len_q;
    assign mwr_last  = draining && (left_q == CW'(1));
    assign pop       = mwr_valid && mwr_ready;

    // Burst state: latch the beat count at start, count beats down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            left_q  <= '0;
            len_q   <= '0;
        end else if (start) begin
            state_q <= DR_BURST;
            left_q  <= count;
            len_q   <= count;
        end else if (pop) begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) state_q <= DR_IDLE;
        end
    end

    p_beat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_valid && !mwr_ready) |=> (mwr_valid && $stable(mwr_addr) && $stable(mwr_data)));
    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && mwr_last) |=> !mwr_valid);
    p_len_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_valid && $past(mwr_valid)) |-> $stable(mwr_len));
endmodule

// File: rtl/pwb_rdpath.sv
// Read path: serves hits from the store with a registered one-cycle response,
// and sends misses to the memory read channel, returning the data one cycle
// after it arrives. One read in flight at a time.
module pwb_rdpath #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_accept,
    input  logic [AW-1:0] rd_addr,
    input  logic          hit,
    input  logic [DW-1:0] hit_data,
    output logic          rd_idle,
    output logic          mrd_valid,
    input  logic          mrd_ready,
    output logic [AW-1:0] mrd_addr,
    input  logic          mrd_rvalid,
    input  logic [DW-1:0] mrd_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_hit
);
    import pwb_pkg::*;

    rd_state_e     state_q;
    logic [AW-1:0] addr_q;

    assign rd_idle   = (state_q == RD_IDLE);
    assign mrd_valid = (state_q == RD_ISSUE);
    assign mrd_addr  = addr_q;

    // Miss sequencing: issue, then wait for the returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (rd_accept && !hit) begin
                    state_q <= RD_ISSUE;
                    addr_q  <= rd_addr;
                end
                RD_ISSUE: if (mrd_ready) state_q <= RD_WAIT;
                RD_WAIT:  if (mrd_rvalid) state_q <= RD_IDLE;
                default:  state_q <= RD_IDLE;
            endcase
        end
    end

    // Response register: hit data or returned memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (rd_accept && hit) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= hit_data;
                rsp_hit   <= 1'b1;
            end else if ((state_q == RD_WAIT) && mrd_rvalid) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= mrd_rdata;
                rsp_hit   <= 1'b0;
            end
        end
    end

    p_hit_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_accept && hit) |=> (rsp_valid && rsp_hit && !mrd_valid));
    p_miss_issues_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_accept && !hit) |=> (mrd_valid && !rsp_valid));
    p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_idle |-> !rd_accept);
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));
endmodule

// File: rtl/pwb_top.sv
// Posted-write buffer with read bypass and forwarding. Accepts one request
// per cycle, queues writes in an address-tagged store, drains them as bursts,
// and serves reads from the store or from memory ahead of queued writes.
// Assumes memory orders an accepted write before any later-accepted read.
module pwb_top #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int HIWAT = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_hit,
    input  logic          flush,
    output logic          mrd_valid,
    input  logic          mrd_ready,
    output logic [AW-1:0] mrd_addr,
    input  logic          mrd_rvalid,
    input  logic [DW-1:0] mrd_rdata,
    output logic          mwr_valid,
    input  logic          mwr_ready,
    output logic [AW-1:0] mwr_addr,
    output logic [DW-1:0] mwr_data,
    output logic [CW-1:0] mwr_len,
    output logic          mwr_last
);
    logic          hit;
    logic [DW-1:0] hit_data;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic [CW-1:0] count;
    logic          full;
    logic          start;
    logic          draining;
    logic          pop;
    logic          rd_idle;
    logic          wr_ok;
    logic          wr_accept;
    logic          rd_accept;

    // Request steering: writes wait for a quiet store, reads for the read path.
    assign wr_ok     = !draining && !start && (!full || hit);
    assign req_ready = req_we ? wr_ok : rd_idle;
    assign wr_accept = req_valid && req_we && wr_ok;
    assign rd_accept = req_valid && !req_we && rd_idle;

    pwb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (req_addr),
        .push      (wr_accept),
        .push_data (req_wdata),
        .pop       (pop),
        .hit       (hit),
        .hit_data  (hit_data),
        .head_addr (head_addr),
        .head_data (head_data),
        .count     (count),
        .full      (full)
    );

    pwb_drain #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .HIWAT(HIWAT)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .flush     (flush),
        .head_addr (head_addr),
        .head_data (head_data),
        .start     (start),
        .draining  (draining),
        .pop       (pop),
        .mwr_valid (mwr_valid),
        .mwr_ready (mwr_ready),
        .mwr_addr  (mwr_addr),
        .mwr_data  (mwr_data),
        .mwr_len   (mwr_len),
        .mwr_last  (mwr_last)
    );

    pwb_rdpath #(.AW(AW), .DW(DW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_accept  (rd_accept),
        .rd_addr    (req_addr),
        .hit        (hit),
        .hit_data   (hit_data),
        .rd_idle    (rd_idle),
        .mrd_valid  (mrd_valid),
        .mrd_ready  (mrd_ready),
        .mrd_addr   (mrd_addr),
        .mrd_rvalid (mrd_rvalid),
        .mrd_rdata  (mrd_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_hit    (rsp_hit)
    );

    p_wr_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        draining |-> !wr_accept);
    p_hold_below_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!draining && !flush && (count < CW'(HIWAT))) |=> !mwr_valid);
    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mwr_valid && (mwr_len == $past(count))));
endmodule

// File: tb/pwb_top_tb.sv
`timescale 1ns/1ps
// Directed bench for pwb_top: one task per scenario, each checks its results.
module pwb_top_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b1;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_hit;
    logic          flush = 1'b0;
    logic          mrd_valid;
    logic          mrd_ready = 1'b1;
    logic [AW-1:0] mrd_addr;
    logic          mrd_rvalid;
    logic [DW-1:0] mrd_rdata;
    logic          mwr_valid;
    logic          mwr_ready = 1'b1;
    logic [AW-1:0] mwr_addr;
    logic [DW-1:0] mwr_data;
    logic [CW-1:0] mwr_len;
    logic          mwr_last;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [DW-1:0] mem [256];
    int            nb = 0;
    int            nrd = 0;
    logic [AW-1:0] lg_a [16];
    logic [DW-1:0] lg_d [16];
    logic [CW-1:0] lg_n [16];
    logic          lg_l [16];
    logic [2:0]    pv = '0;
    logic [DW-1:0] pd0 = '0, pd1 = '0, pd2 = '0;

    always #2 clk = ~clk;

    pwb_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .HIWAT(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
        .flush(flush), .mrd_valid(mrd_valid), .mrd_ready(mrd_ready),
        .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .mwr_valid(mwr_valid), .mwr_ready(mwr_ready), .mwr_addr(mwr_addr),
        .mwr_data(mwr_data), .mwr_len(mwr_len), .mwr_last(mwr_last)
    );

    // Memory model: logs write beats, serves reads after three cycles.
    assign mrd_rvalid = pv[2];
    assign mrd_rdata  = pd2;
    always @(posedge clk) begin
        cyc = cyc + 1;
        pv  <= {pv[1:0], mrd_valid && mrd_ready};
        pd0 <= mem[mrd_addr];
        pd1 <= pd0;
        pd2 <= pd1;
        if (mrd_valid && mrd_ready) nrd = nrd + 1;
        if (mwr_valid && mwr_ready) begin
            if (nb < 16) begin
                lg_a[nb] = mwr_addr; lg_d[nb] = mwr_data;
                lg_n[nb] = mwr_len;  lg_l[nb] = mwr_last;
            end
            mem[mwr_addr] = mwr_data;
            nb = nb + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                           input bit exp_hit, input string req);
        int lat;
        int rd0;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        rd0 = nrd;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b1;
        lat = 1;
        while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
        chk(rsp_valid, req, 32'(rsp_valid), 1);
        chk(rsp_rdata == exp, req, rsp_rdata, exp);
        chk(rsp_hit == exp_hit, req, 32'(rsp_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(lat == 1, {req, " hit latency"}, lat, 1);
            chk(nrd == rd0, {req, " no memory read"}, nrd - rd0, 0);
        end else begin
            chk(nrd == rd0 + 1, {req, " one memory read"}, nrd - rd0, 1);
        end
    endtask

    task automatic wait_burst(input int n);
        int k = 0;
        while ((nb < n || mwr_valid) && k < 80) begin @(negedge clk); k++; end
    endtask

    task automatic check_beat(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input int n, input string req);
        chk(lg_a[i] == a, {req, " beat addr"}, 32'(lg_a[i]), 32'(a));
        chk(lg_d[i] == d, {req, " beat data"}, lg_d[i], d);
        chk(lg_n[i] == CW'(n), {req, " beat len"}, 32'(lg_n[i]), n);
        chk(lg_l[i] == (i == n - 1), {req, " beat last"}, 32'(lg_l[i]), 32'(i == n - 1));
    endtask

    // R1: quiet outputs after reset.
    task automatic t_reset();
        @(negedge clk);
        req_we = 1'b1; #1;
        chk(req_ready, "R1 write ready", 32'(req_ready), 1);
        chk(!mwr_valid && !mrd_valid, "R1 no memory traffic",
            32'({mwr_valid, mrd_valid}), 0);
        chk(!rsp_valid, "R1 no response", 32'(rsp_valid), 0);
    endtask

    // R2, R7, R8, R3: collect five, miss read bypasses, sixth triggers burst.
    task automatic t_collect();
        nb = 0;
        for (int i = 0; i < 5; i++) do_write(8'h10 + 8'(i), 32'hA000 + 32'(i));
        repeat (4) @(negedge clk);
        chk(nb == 0, "R2 held below mark", nb, 0);
        do_read(8'h40, 32'hC0DE_0040, 1'b0, "R7 R8 bypass miss");
        chk(nb == 0, "R8 writes still held", nb, 0);
        do_write(8'h15, 32'hA005);
        wait_burst(6);
        chk(nb == 6, "R3 beat count", nb, 6);
        for (int i = 0; i < 6; i++) check_beat(i, 8'h10 + 8'(i), 32'hA000 + 32'(i), 6, "R3");
    endtask

    // R5, R6, R4: coalescing, hit forwarding, flush of a partial buffer.
    task automatic t_coalesce();
        nb = 0;
        do_write(8'h20, 32'h1111);
        do_write(8'h21, 32'h2222);
        do_write(8'h20, 32'h3333);
        do_read(8'h20, 32'h3333, 1'b1, "R5 R6 newest hit");
        do_read(8'h21, 32'h2222, 1'b1, "R5 second hit");
        repeat (3) @(negedge clk);
        chk(nb == 0, "R2 no drain before flush", nb, 0);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        wait_burst(2);
        chk(nb == 2, "R4 R6 flush beats", nb, 2);
        check_beat(0, 8'h20, 32'h3333, 2, "R6");
        check_beat(1, 8'h21, 32'h2222, 2, "R4");
    endtask

    // R4: flush with nothing held.
    task automatic t_flush_empty();
        nb = 0;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        repeat (10) @(negedge clk);
        chk(nb == 0 && !mwr_valid, "R4 empty flush", nb, 0);
    endtask

    // R9, R10, R7: stalled burst blocks writes, reads still served.
    task automatic t_stall();
        logic [AW-1:0] a0;
        logic [DW-1:0] d0;
        nb = 0;
        mwr_ready = 1'b0;
        for (int i = 0; i < 6; i++) do_write(8'h30 + 8'(i), 32'hB000 + 32'(i));
        repeat (3) @(negedge clk);
        a0 = mwr_addr; d0 = mwr_data;
        @(negedge clk);
        chk(mwr_valid && mwr_addr == a0 && mwr_data == d0, "R10 beat held",
            mwr_data, d0);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 8'h3F; req_wdata = 32'hDEAD;
        #1;
        chk(!req_ready, "R9 write stalled", 32'(req_ready), 0);
        req_valid = 1'b0;
        do_read(8'h32, 32'hB002, 1'b1, "R9 read during drain");
        do_read(8'h41, 32'hC0DE_0041, 1'b0, "R9 miss during drain");
        chk(nb == 0, "R10 nothing taken", nb, 0);
        mwr_ready = 1'b1;
        wait_burst(6);
        chk(nb == 6, "R3 stalled burst beats", nb, 6);
        for (int i = 0; i < 6; i++) check_beat(i, 8'h30 + 8'(i), 32'hB000 + 32'(i), 6, "R10");
        do_read(8'h33, 32'hB003, 1'b0, "R7 miss after drain");
    endtask

    // R11: second read refused while a miss is pending.
    task automatic t_one_read();
        mrd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 8'h50;
        #1;
        chk(req_ready, "R11 first read ready", 32'(req_ready), 1);
        @(negedge clk);
        req_addr = 8'h51;
        #1;
        chk(!req_ready, "R11 second read refused", 32'(req_ready), 0);
        req_valid = 1'b0; req_we = 1'b1;
        repeat (2) @(negedge clk);
        mrd_ready = 1'b1;
        begin
            int k = 0;
            while (!rsp_valid && k < 40) begin @(negedge clk); k++; end
        end
        chk(rsp_valid && rsp_rdata == 32'hC0DE_0050 && !rsp_hit, "R11 R7 pending read data",
            rsp_rdata, 32'hC0DE_0050);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        if (!done && cyc > 100000) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_collect();
        t_coalesce();
        t_flush_empty();
        t_stall();
        t_one_read();
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule